// File: doc/BRIEF.md
# Configurable GPIO Pin Controller

This block looks after one general-purpose pin of a power-management device. A set of configuration fields, taken from registers held elsewhere, chooses what the pin does. In output mode, a function code routes one of several internal status signals to the pin, with optional inversion. The pin can be push-pull or open-drain. In input mode, the pin value is synchronised, polarity-corrected and handed to internal logic. The same input path raises a sticky interrupt flag on the selected edge or edges. The flag is cleared by a write-one-to-clear strobe.

The block drives the pad through four signals: a drive value, an output enable, a pull-up enable and a pull-down enable. The analog pad, the voltage domain, the converter clock generator and the power sequencer sit outside. Their results arrive as plain inputs. The power state arrives as a two-bit code.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After reset the interrupt flag is 0. No interrupt is raised while the input synchroniser is still filling, even when the corrected input level is 1 from the start.
- R2: The output function code selects the active-high source as follows: 0xA external enable 1, 0xB external enable 2, 0xC supply good, 0xD converter good, 0xE gated clock, 0xF auxiliary reset. Every other code selects 0. The pin level equals that source when `cfg_pol`=1 and its inverse when `cfg_pol`=0.
- R3: Code 0xE passes `ext_clk` only while `ext_en1` or `ext_en2` is 1. Otherwise the source is 0.
- R4: Code 0xD passes `conv_good` only while `sys_state` is ON (2'b01) or SLEEP (2'b10). In OFF (2'b00) and in transition (2'b11) the source is 0.
- R5: Code 0xF gives a source of 1 in OFF, `cfg_rst_sleep` in SLEEP, and 0 in ON and in transition.
- R6: Push-pull drive applies with `cfg_ena`=1, `cfg_dir`=1 and `cfg_od`=0. In that mode `pad_oe`=1 and `pad_out` equals the pin level.
- R7: Open-drain drive applies with `cfg_ena`=1, `cfg_dir`=1 and `cfg_od`=1. In that mode `pad_out`=0, and `pad_oe` is 1 exactly when the pin level is 0. With `cfg_dir`=0 the pin is never driven.
- R8: With `cfg_ena`=0, `pad_oe`, `pad_pu`, `pad_pd` and `in_level` are all 0. Changes on `pad_in` raise no interrupt in this state.
- R9: With the pad enabled, `cfg_pull` 2'b10 turns on the pull-up and 2'b01 turns on the pull-down. Codes 2'b00 and 2'b11 turn on neither.
- R10: With the pad enabled, `in_level` equals `pad_in` (when `cfg_pol`=1) or its inverse (when `cfg_pol`=0), delayed by exactly two clock edges.
- R11: With `cfg_irq_both`=0, only a pin edge in the active direction sets the flag: rising when `cfg_pol`=1, falling when `cfg_pol`=0. With `cfg_irq_both`=1, both pin edges set it. The flag is set one edge after `in_level` changes.
- R12: The flag stays set until `irq_clr` is 1 on a clock edge. A new edge event in the same cycle as a clear wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fn | input | 4 | Output function code |
| cfg_dir | input | 1 | 1 = output function, 0 = input function |
| cfg_pol | input | 1 | 1 = active high, 0 = inverted |
| cfg_od | input | 1 | 1 = open-drain drive |
| cfg_ena | input | 1 | 0 = pad disconnected |
| cfg_pull | input | 2 | Pull select (01 down, 10 up) |
| cfg_irq_both | input | 1 | 1 = interrupt on both edges |
| cfg_rst_sleep | input | 1 | Auxiliary reset value in SLEEP |
| ext_en1 | input | 1 | External power enable 1 |
| ext_en2 | input | 1 | External power enable 2 |
| sys_good | input | 1 | System supply good |
| conv_good | input | 1 | Converters good |
| ext_clk | input | 1 | Converter clock |
| sys_state | input | 2 | Power state: 00 OFF, 01 ON, 10 SLEEP, 11 transition |
| pad_in | input | 1 | Raw pin value from pad |
| irq_clr | input | 1 | Write-one-to-clear strobe for the flag |
| pad_out | output | 1 | Pad drive value |
| pad_oe | output | 1 | Pad output enable |
| pad_pu | output | 1 | Pull-up enable |
| pad_pd | output | 1 | Pull-down enable |
| in_level | output | 1 | Synchronised, polarity-corrected input |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The flag assertion assumes that configuration fields, and `pad_in` seen through the synchroniser, change only between clock edges. It relates a rising flag to a change of `in_level` over the two preceding cycles, so it takes for granted that `cfg_pol` and `cfg_ena` are not toggled in the same window in which it looks back. The stimulus drives every input at the falling edge. It changes configuration only while the flag result is not being judged, and it clears the flag before each edge test, so the assumed conditions hold throughout.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'b00,
    ST_ON    = 2'b01,
    ST_SLEEP = 2'b10,
    ST_TRANS = 2'b11
  } pwr_state_e;

  typedef enum logic [1:0] {
    PULL_NONE = 2'b00,
    PULL_DOWN = 2'b01,
    PULL_UP   = 2'b10,
    PULL_RSVD = 2'b11
  } pull_sel_e;

  localparam int CODE_EXT_EN1   = 10;
  localparam int CODE_EXT_EN2   = 11;
  localparam int CODE_SUP_GOOD  = 12;
  localparam int CODE_CONV_GOOD = 13;
  localparam int CODE_EXT_CLK   = 14;
  localparam int CODE_AUX_RST   = 15;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = 1'b1;
      end else begin : g_next
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_out_sel.sv
module gpio_out_sel
  import gpio_pin_pkg::*;
#(
  parameter int FN_W = 4
) (
  input  logic [FN_W-1:0] cfg_fn,
  input  logic            cfg_pol,
  input  logic            cfg_rst_sleep,
  input  logic            ext_en1,
  input  logic            ext_en2,
  input  logic            sys_good,
  input  logic            conv_good,
  input  logic            ext_clk,
  input  logic [1:0]      sys_state,
  output logic            pin_level
);
  logic active;
  logic st_running;
  logic aux_rst;
  logic clk_gated;

  always_comb begin
    st_running = (sys_state == ST_ON) || (sys_state == ST_SLEEP);
    clk_gated  = ext_clk & (ext_en1 | ext_en2);
    case (sys_state)
      ST_OFF:   aux_rst = 1'b1;
      ST_SLEEP: aux_rst = cfg_rst_sleep;
      default:  aux_rst = 1'b0;
    endcase
  end

  always_comb begin
    active = 1'b0;
    if      (cfg_fn == FN_W'(CODE_EXT_EN1))   active = ext_en1;
    else if (cfg_fn == FN_W'(CODE_EXT_EN2))   active = ext_en2;
    else if (cfg_fn == FN_W'(CODE_SUP_GOOD))  active = sys_good;
    else if (cfg_fn == FN_W'(CODE_CONV_GOOD)) active = conv_good & st_running;
    else if (cfg_fn == FN_W'(CODE_EXT_CLK))   active = clk_gated;
    else if (cfg_fn == FN_W'(CODE_AUX_RST))   active = aux_rst;
  end

  assign pin_level = active ^ ~cfg_pol;
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_pin_pkg::*;
(
  input  logic       cfg_ena,
  input  logic       cfg_dir,
  input  logic       cfg_od,
  input  logic [1:0] cfg_pull,
  input  logic       pin_level,
  output logic       pad_out,
  output logic       pad_oe,
  output logic       pad_pu,
  output logic       pad_pd
);
  logic drive_on;

  always_comb begin
    drive_on = cfg_ena & cfg_dir;
    if (cfg_od) begin
      pad_out = 1'b0;
      pad_oe  = drive_on & ~pin_level;
    end else begin
      pad_out = pin_level;
      pad_oe  = drive_on;
    end
    pad_pu = cfg_ena & (cfg_pull == PULL_UP);
    pad_pd = cfg_ena & (cfg_pull == PULL_DOWN);
  end
endmodule

// File: rtl/gpio_in_path.sv
module gpio_in_path #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_ena,
  input  logic cfg_pol,
  input  logic cfg_irq_both,
  input  logic pad_in,
  input  logic irq_clr,
  output logic in_level,
  output logic irq_flag
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [SYNC_STAGES:0]   prime_q, prime_d;
  logic                   prev_q, prev_d;
  logic                   flag_q, flag_d, flag_en;
  logic                   corr, rise, fall, evt;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_head
        assign sync_d[i] = pad_in;
      end else begin : g_tail
        assign sync_d[i] = sync_q[i-1];
      end
    end
  endgenerate

  always_comb begin
    corr    = cfg_ena ? (sync_q[LAST] ^ ~cfg_pol) : 1'b0;
    prev_d  = corr;
    prime_d = {prime_q[SYNC_STAGES-1:0], 1'b1};
    rise    = corr & ~prev_q;
    fall    = ~corr & prev_q;
    evt     = prime_q[SYNC_STAGES] & (cfg_irq_both ? (rise | fall) : rise);
    flag_en = evt | irq_clr;
    flag_d  = (flag_q & ~irq_clr) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      prime_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      prime_q <= prime_d;
      prev_q  <= prev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign in_level = corr;
  assign irq_flag = flag_q;
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
  parameter int FN_W        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FN_W-1:0] cfg_fn,
  input  logic            cfg_dir,
  input  logic            cfg_pol,
  input  logic            cfg_od,
  input  logic            cfg_ena,
  input  logic [1:0]      cfg_pull,
  input  logic            cfg_irq_both,
  input  logic            cfg_rst_sleep,
  input  logic            ext_en1,
  input  logic            ext_en2,
  input  logic            sys_good,
  input  logic            conv_good,
  input  logic            ext_clk,
  input  logic [1:0]      sys_state,
  input  logic            pad_in,
  input  logic            irq_clr,
  output logic            pad_out,
  output logic            pad_oe,
  output logic            pad_pu,
  output logic            pad_pd,
  output logic            in_level,
  output logic            irq_flag
);
  logic rst_core_n;
  logic pin_level;

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  gpio_out_sel #(.FN_W(FN_W)) u_sel (
    .cfg_fn        (cfg_fn),
    .cfg_pol       (cfg_pol),
    .cfg_rst_sleep (cfg_rst_sleep),
    .ext_en1       (ext_en1),
    .ext_en2       (ext_en2),
    .sys_good      (sys_good),
    .conv_good     (conv_good),
    .ext_clk       (ext_clk),
    .sys_state     (sys_state),
    .pin_level     (pin_level)
  );

  gpio_pad_drive u_drv (
    .cfg_ena   (cfg_ena),
    .cfg_dir   (cfg_dir),
    .cfg_od    (cfg_od),
    .cfg_pull  (cfg_pull),
    .pin_level (pin_level),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd)
  );

  gpio_in_path #(.SYNC_STAGES(SYNC_STAGES)) u_in (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .cfg_ena      (cfg_ena),
    .cfg_pol      (cfg_pol),
    .cfg_irq_both (cfg_irq_both),
    .pad_in       (pad_in),
    .irq_clr      (irq_clr),
    .in_level     (in_level),
    .irq_flag     (irq_flag)
  );
endmodule

// File: rtl/gpio_pin_ctrl_chk.sv
module gpio_pin_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_ena,
  input logic cfg_dir,
  input logic cfg_od,
  input logic pad_out,
  input logic pad_oe,
  input logic pad_pu,
  input logic pad_pd,
  input logic in_level,
  input logic irq_flag,
  input logic irq_clr
);
  assert_tristate_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ena |-> (!pad_oe && !pad_pu && !pad_pd && !in_level));

  assert_pulls_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pad_pu && pad_pd));

  assert_od_never_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_od && pad_oe) |-> !pad_out);

  assert_input_not_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dir |-> !pad_oe);

  assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  assert_flag_needs_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> ($past(in_level) != $past(in_level, 2)));
endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_ena  (cfg_ena),
  .cfg_dir  (cfg_dir),
  .cfg_od   (cfg_od),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .pad_pu   (pad_pu),
  .pad_pd   (pad_pd),
  .in_level (in_level),
  .irq_flag (irq_flag),
  .irq_clr  (irq_clr)
);

// File: tb/tb_gpio_pin_ctrl.sv
module tb_gpio_pin_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] cfg_fn;
  logic       cfg_dir, cfg_pol, cfg_od, cfg_ena, cfg_irq_both, cfg_rst_sleep;
  logic [1:0] cfg_pull;
  logic       ext_en1, ext_en2, sys_good, conv_good, ext_clk;
  logic [1:0] sys_state;
  logic       pad_in, irq_clr;
  logic       pad_out, pad_oe, pad_pu, pad_pd, in_level, irq_flag;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_pin_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_fn(cfg_fn), .cfg_dir(cfg_dir),
    .cfg_pol(cfg_pol), .cfg_od(cfg_od), .cfg_ena(cfg_ena), .cfg_pull(cfg_pull),
    .cfg_irq_both(cfg_irq_both), .cfg_rst_sleep(cfg_rst_sleep),
    .ext_en1(ext_en1), .ext_en2(ext_en2), .sys_good(sys_good),
    .conv_good(conv_good), .ext_clk(ext_clk), .sys_state(sys_state),
    .pad_in(pad_in), .irq_clr(irq_clr), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .in_level(in_level), .irq_flag(irq_flag)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  function automatic logic src_of(input int fn, input logic e1, input logic e2,
                                  input logic sg, input logic cg, input logic ck,
                                  input int st, input logic rs);
    case (fn)
      10: return e1;
      11: return e2;
      12: return sg;
      13: return cg && (st == 1 || st == 2);
      14: return ck && (e1 || e2);
      15: return (st == 0) ? 1'b1 : (st == 2) ? rs : 1'b0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic next_neg();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_flag();
    irq_clr = 1'b1;
    next_neg();
    irq_clr = 1'b0;
  endtask

  // One edge test: pin moves from 'from' to ~from with polarity p and mode b.
  task automatic edge_test(input logic p, input logic b, input logic from);
    logic exp_fire;
    cfg_pol = p; cfg_irq_both = b; pad_in = from;
    repeat (4) next_neg();
    clear_flag();
    chk("R12 flag cleared", irq_flag, 1'b0);
    pad_in = ~from;
    next_neg();
    chk("R10 in_level one edge", in_level, from ^ ~p);
    next_neg();
    chk("R10 in_level two edges", in_level, ~from ^ ~p);
    chk("R11 flag not yet", irq_flag, 1'b0);
    next_neg();
    exp_fire = b | ((~from) == p);
    chk("R11 edge select", irq_flag, exp_fire);
  endtask

  initial begin
    rst_n = 1'b0; cfg_fn = 4'h0; cfg_dir = 1'b0; cfg_pol = 1'b0; cfg_od = 1'b0;
    cfg_ena = 1'b1; cfg_pull = 2'b00; cfg_irq_both = 1'b1; cfg_rst_sleep = 1'b0;
    ext_en1 = 1'b0; ext_en2 = 1'b0; sys_good = 1'b0; conv_good = 1'b0;
    ext_clk = 1'b0; sys_state = 2'b00; pad_in = 1'b0; irq_clr = 1'b0;
    repeat (3) next_neg();
    chk("R1 flag in reset", irq_flag, 1'b0);
    rst_n = 1'b1;
    // pol=0, pin 0: corrected level is 1 from the start; no interrupt may follow
    repeat (8) next_neg();
    chk("R1 no flag after settle", irq_flag, 1'b0);
    chk("R10 inverted idle level", in_level, 1'b1);

    // Output function sweep (R2..R5)
    cfg_dir = 1'b1; cfg_od = 1'b0; cfg_ena = 1'b1;
    for (int c = 0; c < 8192; c++) begin
      int fn, st;
      logic p, e1, e2, sg, cg, ck, rs, exp;
      string tag;
      fn = c & 15; p = c[4]; e1 = c[5]; e2 = c[6]; sg = c[7]; cg = c[8];
      ck = c[9]; st = (c >> 10) & 3; rs = c[12];
      cfg_fn = fn[3:0]; cfg_pol = p; ext_en1 = e1; ext_en2 = e2; sys_good = sg;
      conv_good = cg; ext_clk = ck; sys_state = st[1:0]; cfg_rst_sleep = rs;
      #1;
      exp = src_of(fn, e1, e2, sg, cg, ck, st, rs) ^ ~p;
      tag = (fn == 14) ? "R3 clock gating" : (fn == 13) ? "R4 conv good" :
            (fn == 15) ? "R5 aux reset" : "R2 function mux";
      chk(tag, pad_out, exp);
    end

    // Pad drive sweep (R6..R9): source is ext_en1 with pol=1
    cfg_fn = 4'hA; cfg_pol = 1'b1;
    for (int c = 0; c < 64; c++) begin
      logic od, en, dr, lv, eoe, eout;
      logic [1:0] pl;
      od = c[0]; en = c[1]; dr = c[2]; lv = c[3]; pl = c[5:4];
      cfg_od = od; cfg_ena = en; cfg_dir = dr; ext_en1 = lv; cfg_pull = pl;
      #1;
      eoe  = en & dr & (od ? ~lv : 1'b1);
      eout = od ? 1'b0 : lv;
      chk(od ? "R7 open-drain oe" : "R6 push-pull oe", pad_oe, eoe);
      if (eoe) chk(od ? "R7 open-drain value" : "R6 push-pull value", pad_out, eout);
      chk(en ? "R9 pull-up" : "R8 pull-up off", pad_pu, en & (pl == 2'b10));
      chk(en ? "R9 pull-down" : "R8 pull-down off", pad_pd, en & (pl == 2'b01));
    end

    // Input path and interrupt edge selection (R10, R11, R12)
    @(negedge clk);
    cfg_dir = 1'b0; cfg_ena = 1'b1; cfg_pull = 2'b00;
    for (int c = 0; c < 8; c++) edge_test(c[0], c[1], c[2]);

    // Set wins over clear in the same cycle (R12); flag is set at this point
    cfg_pol = 1'b1; cfg_irq_both = 1'b1; pad_in = 1'b0;
    repeat (4) next_neg();
    clear_flag();
    pad_in = 1'b1;
    repeat (3) next_neg();
    chk("R12 flag set by edge", irq_flag, 1'b1);
    pad_in = 1'b0;
    repeat (2) next_neg();
    irq_clr = 1'b1;
    next_neg();
    irq_clr = 1'b0;
    chk("R12 set beats clear", irq_flag, 1'b1);
    repeat (2) next_neg();
    chk("R12 sticky without clear", irq_flag, 1'b1);

    // Disabled pad: input held inactive, toggles ignored (R8)
    clear_flag();
    cfg_ena = 1'b0; pad_in = 1'b1;
    #1 chk("R8 input disconnected", in_level, 1'b0);
    for (int k = 0; k < 6; k++) begin
      pad_in = ~pad_in;
      next_neg();
    end
    pad_in = 1'b0;
    repeat (4) next_neg();
    chk("R8 no flag while disabled", irq_flag, 1'b0);
    cfg_ena = 1'b1;
    repeat (4) next_neg();
    chk("R8 no flag after re-enable", irq_flag, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog act=running exp=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule